// File: doc/BRIEF.md
# Self-Timed Programming Sequencer

This block sits behind the serial command decoder of a small non-volatile memory model. The decoder hands it a complete request (an operation code, a word address and a data word) and two markers from the serial line: the chip-select level and a pulse whenever a new start bit has been recognised. The block keeps the write-permission latch, launches a self-timed programming cycle on the falling edge of chip select, updates the word array, and tells the output multiplexer what to put on the serial data line while a cycle is running and after it ends.

The cycle is timed by a counter on the free-running system clock, so it finishes whether or not the serial clock keeps toggling. Whole-array operations step through the array one word per system clock over the first part of the cycle, using a single write port. A registered read port lets the front end fetch words for normal reads. Read requests do not depend on the permission latch.

Top module: `prog_sequencer`

## Requirements
- R1: After synchronous reset the permission latch is cleared, every array word reads all ones, no cycle runs and `stat_en` is 0.
- R2: Operation codes are 0 none, 1 erase word, 2 write word, 3 erase all, 4 write all, 5 enable, 6 disable, 7 read. A captured enable (5) or disable (6) sets or clears the permission latch at the next chip-select fall. With the latch clear, codes 1 to 4 start no cycle and leave the array unchanged.
- R3: A cycle starts only at the chip-select fall following a captured code 1 to 4 while the latch is set, and lasts exactly `CYCLE_LEN` system clocks.
- R4: Erase word sets every bit of the addressed word to 1 and leaves other words untouched.
- R5: Write word leaves exactly the supplied data in the addressed word, whatever it held before.
- R6: Erase all sets every word to all ones.
- R7: Write all leaves each word equal to its previous value ANDed with the supplied data.
- R8: While a cycle runs and chip select is high, `stat_en` is 1 and `stat_bit` is 0; once the cycle ends, `stat_bit` becomes 1.
- R9: The ready indication stays available after a cycle until a start-bit pulse arrives or chip select falls; after either, raising chip select gives `stat_en` = 0.
- R10: Requests, start bits and chip-select falls arriving during a cycle are ignored; the permission latch cannot change during a cycle.

Top module ports in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst | input | 1 | synchronous active-high reset |
| sel | input | 1 | chip-select level from the serial pins |
| start_pulse | input | 1 | one-clock pulse when a start bit is decoded |
| req_valid | input | 1 | one-clock pulse with a complete request |
| req_op | input | 3 | operation code (see R2) |
| req_addr | input | AW | word address |
| req_data | input | DW | data word |
| rd_addr | input | AW | front-end read address |
| rd_data | output | DW | word at `rd_addr`, one clock later |
| stat_en | output | 1 | serial output should carry the status bit |
| stat_bit | output | 1 | 0 busy, 1 ready |

## Verification
Write word is tried on a fresh all-ones word and then over a word already holding the complement pattern, which tells a true replace from a plain AND. Write all is applied over an array that holds one distinct word among erased ones, so the AND result differs per word and a mere overwrite is exposed. Commands are issued with the latch clear, with it set, and in the middle of a running cycle, which separates gating from timing; the busy span is counted clock by clock against `CYCLE_LEN`, and the ready indication is probed after a chip-select fall and after a start bit separately.

// File: rtl/prog_pkg.sv
package prog_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_WRITE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_EN    = 3'd5,
    OP_DIS   = 3'd6,
    OP_READ  = 3'd7
  } op_t;

  function automatic logic is_prog(input op_t op);
    return (op == OP_ERASE) || (op == OP_WRITE) || (op == OP_ERAL) || (op == OP_WRAL);
  endfunction

  function automatic logic is_whole(input op_t op);
    return (op == OP_ERAL) || (op == OP_WRAL);
  endfunction
endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYCLE_LEN = 40,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(CYCLE_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a cycle ends only after the full count
  assert_cycle_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt) == LAST);
  // R3: the count never runs past its end
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= LAST);
endmodule

// File: rtl/prog_array.sv
module prog_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] maddr,
  output logic [DW-1:0] mdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      rdata <= '1;
    end else begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
    end
  end

  assign mdata = cells[maddr];
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CYCLE_LEN = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          start_pulse,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          stat_en,
  output logic          stat_bit
);
  import prog_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int TW = $clog2(CYCLE_LEN + 1);
  localparam int CW = (TW > AW + 1) ? TW : AW + 1;

  logic          sel_q, sel_fall;
  logic          armed, wr_ok, shown;
  op_t           p_op;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic          go, busy;
  logic [CW-1:0] cnt;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata, cur;

  assign sel_fall = sel_q & ~sel;
  assign go = sel_fall & armed & ~busy & wr_ok & is_prog(p_op);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      armed  <= 1'b0;
      wr_ok  <= 1'b0;
      shown  <= 1'b0;
      p_op   <= OP_NONE;
      p_addr <= '0;
      p_data <= '0;
    end else begin
      sel_q <= sel;
      if (!busy) begin
        if (req_valid) begin
          armed  <= 1'b1;
          p_op   <= op_t'(req_op);
          p_addr <= req_addr;
          p_data <= req_data;
        end else if (start_pulse || sel_fall) begin
          armed <= 1'b0;
        end
        if (sel_fall && armed) begin
          if (p_op == OP_EN)  wr_ok <= 1'b1;
          if (p_op == OP_DIS) wr_ok <= 1'b0;
        end
      end
      if (go) shown <= 1'b1;
      else if (!busy && (start_pulse || sel_fall)) shown <= 1'b0;
    end
  end

  prog_timer #(.CYCLE_LEN(CYCLE_LEN), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .cnt(cnt)
  );

  always_comb begin
    if (is_whole(p_op)) begin
      we    = busy && (cnt < CW'(DEPTH));
      waddr = cnt[AW-1:0];
    end else begin
      we    = busy && (cnt == '0);
      waddr = p_addr;
    end
    case (p_op)
      OP_WRITE: wdata = p_data;
      OP_WRAL:  wdata = cur & p_data;
      default:  wdata = '1;
    endcase
  end

  prog_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_data), .maddr(waddr), .mdata(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_en  <= 1'b0;
      stat_bit <= 1'b1;
    end else begin
      stat_en  <= sel & shown;
      stat_bit <= ~busy;
    end
  end

  // R2: a cycle is only launched with the permission latch set
  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_ok));
  // R3: launch coincides with a chip-select fall
  assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(sel_q) && !$past(sel)));
  // R8: status is offered only while chip select was high
  assert_stat_sel_R8: assert property (@(posedge clk) disable iff (rst)
    stat_en |-> $past(sel));
  // R10: the permission latch holds during a cycle
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wr_ok));
endmodule

// File: tb/tb_prog_sequencer.sv
module tb_prog_sequencer;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int L  = 24;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, start_pulse = 1'b0, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [DW-1:0] rd_data;
  logic stat_en, stat_bit;

  int total = 0, bad = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  prog_sequencer #(.AW(AW), .DW(DW), .CYCLE_LEN(L)) dut (
    .clk(clk), .rst(rst), .sel(sel), .start_pulse(start_pulse),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stat_en(stat_en), .stat_bit(stat_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); sel = 1'b1; start_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0; req_valid = 1'b1;
    req_op = op; req_addr = a; req_data = d;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    @(negedge clk); sel = 1'b1;
    for (int i = 0; i < L + 10; i++) begin
      @(negedge clk);
      if (stat_en && stat_bit) break;
    end
    sel = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic check_array(input string req);
    logic [DW-1:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      read_word(AW'(i), v);
      check(req, v, ref_mem[i]);
    end
  endtask

  task automatic probe_idle(input string req);
    @(negedge clk); sel = 1'b1;
    @(negedge clk); @(negedge clk);
    check(req, stat_en, 0);
    sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 stat_en", stat_en, 0);
    check_array("R1 array");
    probe_idle("R1 no cycle");
  endtask

  task automatic t_locked();
    issue(3'd2, 4'd3, 8'h12);
    probe_idle("R2 locked write no cycle");
    issue(3'd3, 4'd0, 8'h00);
    check_array("R2 locked array");
  endtask

  task automatic t_enable_write();
    int nbusy = 0;
    issue(3'd5, 4'd0, 8'h00);
    issue(3'd2, 4'd3, 8'h5A);
    ref_mem[3] = 8'h5A;
    sel = 1'b1;
    for (int i = 0; i < L + 10; i++) begin
      @(negedge clk);
      if (stat_en && !stat_bit) nbusy++;
      if (stat_en && stat_bit) break;
    end
    check("R3 busy length", nbusy, L);
    check("R8 ready bit", stat_bit, 1);
    check("R8 ready en", stat_en, 1);
    sel = 1'b0;
    @(negedge clk); @(negedge clk);
    check_array("R5 write");
    issue(3'd2, 4'd3, 8'hA5);
    ref_mem[3] = 8'hA5;
    wait_ready();
    check_array("R5 overwrite");
  endtask

  task automatic t_ready_hold();
    issue(3'd2, 4'd7, 8'h81);
    ref_mem[7] = 8'h81;
    @(negedge clk); sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 busy bit", stat_bit, 0);
    check("R8 busy en", stat_en, 1);
    repeat (L + 2) @(negedge clk);
    check("R9 ready while held", stat_en & stat_bit, 1);
    start_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0;
    @(negedge clk);
    check("R9 start clears", stat_en, 0);
    sel = 1'b0;
    @(negedge clk);
    issue(3'd1, 4'd7, 8'h00);
    ref_mem[7] = 8'hFF;
    repeat (L + 4) @(negedge clk);
    @(negedge clk); sel = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 ready kept with sel low", stat_en & stat_bit, 1);
    sel = 1'b0;
    @(negedge clk);
    probe_idle("R9 sel fall clears");
    check_array("R4 erase word");
  endtask

  task automatic t_busy_ignore();
    issue(3'd2, 4'd5, 8'h33);
    ref_mem[5] = 8'h33;
    issue(3'd6, 4'd0, 8'h00);
    wait_ready();
    issue(3'd2, 4'd6, 8'h44);
    ref_mem[6] = 8'h44;
    wait_ready();
    check_array("R10 ignored during cycle");
  endtask

  task automatic t_whole();
    issue(3'd3, 4'd0, 8'h00);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
    wait_ready();
    check_array("R6 erase all");
    issue(3'd2, 4'd2, 8'h0F);
    ref_mem[2] = 8'h0F;
    wait_ready();
    issue(3'd4, 4'd0, 8'h3C);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = ref_mem[i] & 8'h3C;
    wait_ready();
    check_array("R7 write all");
  endtask

  task automatic t_disable();
    issue(3'd6, 4'd0, 8'h00);
    issue(3'd3, 4'd0, 8'h00);
    probe_idle("R2 disabled no cycle");
    check_array("R2 disabled array");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_locked();
    t_enable_write();
    t_ready_hold();
    t_busy_ignore();
    t_whole();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule